// File: doc/BRIEF.md
# Byte-Lane Memory Chip-Select Decoder

This block turns the word address, address strobe and the two data strobes of a 16-bit asynchronous processor bus into active-low chip selects for a small memory map. Every region is built from two byte-wide devices, one on each lane of the data bus. The bus has no A0 line, so each region's select is split into an upper-lane enable and a lower-lane enable. The upper data strobe drives the upper-lane enable and the lower data strobe drives the lower-lane enable.

The low 128 KB of the address space is cut into eight 16 KB blocks, picked by byte-address bits 16..14. The boot ROM sits in block 0, so the two reset vectors at byte addresses 0x000000 and 0x000004 are read from ROM. RAM sits in block 1 and the peripheral window sits in block 7. The other blocks, and every address at or above 0x020000, select nothing.

The whole decode is gated by the address strobe. A `decoded` flag tells wait-state or bus-timeout logic that some device answers the current access. The block is purely combinational and has no clock.

Top module: `memsel_decoder`

## Requirements
- R1: While `as_n` is 1, all six lane selects are 1 and `decoded` is 0, for every address and strobe value.
- R2: With a region selected and both `uds_n` and `lds_n` at 0, both of that region's lane selects are 0 (word access).
- R3: With a region selected, `uds_n` at 0 and `lds_n` at 1, only the upper-lane select (data bits 15..8) of that region is 0.
- R4: With a region selected, `lds_n` at 0 and `uds_n` at 1, only the lower-lane select (data bits 7..0) of that region is 0.
- R5: With a region selected and both data strobes at 1, no lane select is 0, but `decoded` is still 1.
- R6: The ROM selects answer byte addresses 0x000000 to 0x003FFF (block 0), which include the reset vectors at 0x000000 and 0x000004.
- R7: The RAM selects answer byte addresses 0x004000 to 0x007FFF (block 1).
- R8: The peripheral selects answer byte addresses 0x01C000 to 0x01FFFF (block 7).
- R9: For blocks 2 to 6, and for any byte address with a bit above bit 16 set, no select is 0 and `decoded` is 0.
- R10: `decoded` is 1 exactly when `as_n` is 0 and the address lies in the ROM, RAM or peripheral region, whatever the data strobes are.
- R11: At no time do the selects of more than one region assert together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper data strobe (bits 15..8), active low |
| lds_n | input | 1 | Lower data strobe (bits 7..0), active low |
| addr_w | input | 23 | Word address, byte-address bits 23..1 |
| rom_hi_cs_n | output | 1 | ROM upper-lane select, active low |
| rom_lo_cs_n | output | 1 | ROM lower-lane select, active low |
| ram_hi_cs_n | output | 1 | RAM upper-lane select, active low |
| ram_lo_cs_n | output | 1 | RAM lower-lane select, active low |
| io_hi_cs_n | output | 1 | Peripheral upper-lane select, active low |
| io_lo_cs_n | output | 1 | Peripheral lower-lane select, active low |
| decoded | output | 1 | Some populated region is addressed |

## Verification
The bench sweeps every combination of the three strobes against all eight blocks. Each block is tried at its first word, at the word holding byte 0x000004 and at its last word. Each of these is repeated with no high address bit set, with bit 17 set and with bit 23 set.

This sweep catches several likely faults:
- A decoder that ignores the address strobe drives selects while the bus is idle.
- Swapped lane strobes show up as the wrong byte lane selected on single-byte cycles.
- A decode that leaves out the high bits aliases ROM at 0x020000 and above.
- A wrong block field moves RAM or the peripheral window away from blocks 1 and 7, or lets the reset vector at byte 4 miss the ROM.
- A `decoded` flag that follows the lane selects instead of the region goes low when both strobes are negated.

// File: rtl/memsel_pkg.sv
package memsel_pkg;

    // Populated regions; RGN_NONE covers holes and out-of-window addresses.
    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_ROM  = 2'd1,
        RGN_RAM  = 2'd2,
        RGN_IO   = 2'd3
    } rgn_e;

    // Index of each populated region in the per-region select vectors.
    localparam int IDX_ROM = 0;
    localparam int IDX_RAM = 1;
    localparam int IDX_IO  = 2;
    localparam int NUM_RGN = 3;

endpackage

// File: rtl/memsel_region_map.sv
module memsel_region_map
    import memsel_pkg::*;
#(
    parameter int WORD_AW   = 23,  // word address width (byte bits 23..1)
    parameter int BLK_SHIFT = 14,  // log2 of block size in bytes
    parameter int BLK_W     = 3,   // number of block-select bits
    parameter int ROM_BLK   = 0,
    parameter int RAM_BLK   = 1,
    parameter int IO_BLK    = 7
) (
    input  logic [WORD_AW-1:0] addr_w,
    output rgn_e               rgn
);
    // Word bit k carries byte bit k+1.
    localparam int BLK_LO = BLK_SHIFT - 1;
    localparam int BLK_HI = BLK_LO + BLK_W - 1;
    localparam logic [BLK_W-1:0] ROM_CODE = BLK_W'(ROM_BLK);
    localparam logic [BLK_W-1:0] RAM_CODE = BLK_W'(RAM_BLK);
    localparam logic [BLK_W-1:0] IO_CODE  = BLK_W'(IO_BLK);

    logic [BLK_W-1:0] blk;
    logic             in_win;

    always_comb begin
        blk    = addr_w[BLK_HI:BLK_LO];
        in_win = (addr_w[WORD_AW-1:BLK_HI+1] == '0);
        rgn    = RGN_NONE;
        if (in_win) begin
            if (blk == ROM_CODE) begin
                rgn = RGN_ROM;
            end else if (blk == RAM_CODE) begin
                rgn = RGN_RAM;
            end else if (blk == IO_CODE) begin
                rgn = RGN_IO;
            end
        end
    end

endmodule

// File: rtl/memsel_lane_gate.sv
module memsel_lane_gate (
    input  logic sel,     // region selected while strobe active
    input  logic uds_n,
    input  logic lds_n,
    output logic hi_cs_n,
    output logic lo_cs_n
);
    always_comb begin
        hi_cs_n = ~(sel & ~uds_n);
        lo_cs_n = ~(sel & ~lds_n);
    end
endmodule

// File: rtl/memsel_decoder.sv
module memsel_decoder
    import memsel_pkg::*;
#(
    parameter int WORD_AW   = 23,
    parameter int BLK_SHIFT = 14,
    parameter int BLK_W     = 3,
    parameter int ROM_BLK   = 0,
    parameter int RAM_BLK   = 1,
    parameter int IO_BLK    = 7
) (
    input  logic               as_n,
    input  logic               uds_n,
    input  logic               lds_n,
    input  logic [WORD_AW-1:0] addr_w,
    output logic               rom_hi_cs_n,
    output logic               rom_lo_cs_n,
    output logic               ram_hi_cs_n,
    output logic               ram_lo_cs_n,
    output logic               io_hi_cs_n,
    output logic               io_lo_cs_n,
    output logic               decoded
);
    rgn_e               rgn;
    logic [NUM_RGN-1:0] sel;
    logic [NUM_RGN-1:0] hi_n;
    logic [NUM_RGN-1:0] lo_n;

    memsel_region_map #(
        .WORD_AW  (WORD_AW),
        .BLK_SHIFT(BLK_SHIFT),
        .BLK_W    (BLK_W),
        .ROM_BLK  (ROM_BLK),
        .RAM_BLK  (RAM_BLK),
        .IO_BLK   (IO_BLK)
    ) u_map (
        .addr_w(addr_w),
        .rgn   (rgn)
    );

    // Region one-hot, qualified by the address strobe.
    always_comb begin
        sel = '0;
        if (!as_n) begin
            unique case (rgn)
                RGN_ROM:  sel[IDX_ROM] = 1'b1;
                RGN_RAM:  sel[IDX_RAM] = 1'b1;
                RGN_IO:   sel[IDX_IO]  = 1'b1;
                RGN_NONE: sel = '0;
            endcase
        end
    end

    for (genvar gi = 0; gi < NUM_RGN; gi++) begin : g_lane
        memsel_lane_gate u_gate (
            .sel    (sel[gi]),
            .uds_n  (uds_n),
            .lds_n  (lds_n),
            .hi_cs_n(hi_n[gi]),
            .lo_cs_n(lo_n[gi])
        );
    end

    assign rom_hi_cs_n = hi_n[IDX_ROM];
    assign rom_lo_cs_n = lo_n[IDX_ROM];
    assign ram_hi_cs_n = hi_n[IDX_RAM];
    assign ram_lo_cs_n = lo_n[IDX_RAM];
    assign io_hi_cs_n  = hi_n[IDX_IO];
    assign io_lo_cs_n  = lo_n[IDX_IO];
    assign decoded     = |sel;

endmodule

// File: rtl/memsel_decoder_chk.sv
module memsel_decoder_chk (
    input logic        as_n,
    input logic        uds_n,
    input logic        lds_n,
    input logic [22:0] addr_w,
    input logic        rom_hi_cs_n,
    input logic        rom_lo_cs_n,
    input logic        ram_hi_cs_n,
    input logic        ram_lo_cs_n,
    input logic        io_hi_cs_n,
    input logic        io_lo_cs_n,
    input logic        decoded
);
    logic [5:0] cs_n;
    logic [2:0] rgn_on;
    assign cs_n   = {rom_hi_cs_n, rom_lo_cs_n, ram_hi_cs_n,
                     ram_lo_cs_n, io_hi_cs_n, io_lo_cs_n};
    assign rgn_on = {~(rom_hi_cs_n & rom_lo_cs_n),
                     ~(ram_hi_cs_n & ram_lo_cs_n),
                     ~(io_hi_cs_n & io_lo_cs_n)};

    always_comb begin
        // R1
        idle_bus_chk: assert (!as_n || (&cs_n && !decoded));
        // R3
        upper_lane_chk: assert (!uds_n || (rom_hi_cs_n && ram_hi_cs_n && io_hi_cs_n));
        // R4
        lower_lane_chk: assert (!lds_n || (rom_lo_cs_n && ram_lo_cs_n && io_lo_cs_n));
        // R9
        high_addr_chk: assert ((addr_w[22:16] == 7'd0) || (&cs_n && !decoded));
        // R10
        decoded_flag_chk: assert ((&cs_n) || decoded);
        // R11
        one_region_chk: assert ($onehot0(rgn_on));
        // R6
        reset_vec_chk: assert (as_n || uds_n || (addr_w != 23'd2) || !rom_hi_cs_n == 1'b1);
    end
endmodule

bind memsel_decoder memsel_decoder_chk u_chk (
    .as_n       (as_n),
    .uds_n      (uds_n),
    .lds_n      (lds_n),
    .addr_w     (addr_w),
    .rom_hi_cs_n(rom_hi_cs_n),
    .rom_lo_cs_n(rom_lo_cs_n),
    .ram_hi_cs_n(ram_hi_cs_n),
    .ram_lo_cs_n(ram_lo_cs_n),
    .io_hi_cs_n (io_hi_cs_n),
    .io_lo_cs_n (io_lo_cs_n),
    .decoded    (decoded)
);

// File: tb/memsel_decoder_test.sv
module memsel_decoder_test;
    logic        clk = 1'b0;
    logic        as_n = 1'b1;
    logic        uds_n = 1'b1;
    logic        lds_n = 1'b1;
    logic [22:0] addr_w = '0;
    logic        rom_hi_cs_n, rom_lo_cs_n, ram_hi_cs_n, ram_lo_cs_n;
    logic        io_hi_cs_n, io_lo_cs_n, decoded;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    memsel_decoder uut (
        .as_n       (as_n),
        .uds_n      (uds_n),
        .lds_n      (lds_n),
        .addr_w     (addr_w),
        .rom_hi_cs_n(rom_hi_cs_n),
        .rom_lo_cs_n(rom_lo_cs_n),
        .ram_hi_cs_n(ram_hi_cs_n),
        .ram_lo_cs_n(ram_lo_cs_n),
        .io_hi_cs_n (io_hi_cs_n),
        .io_lo_cs_n (io_lo_cs_n),
        .decoded    (decoded)
    );

    function automatic string req_tags(input bit asn, input bit u, input bit l,
                                       input int byte_a);
        string s;
        int blk;
        blk = byte_a / 16384;
        if (asn) return "R1";
        if (byte_a >= 32'h20000 || (blk >= 2 && blk <= 6)) return "R9 R10";
        case (blk)
            0: s = "R6";
            1: s = "R7";
            default: s = "R8";
        endcase
        if (!u && !l)     s = {s, " R2"};
        else if (!u)      s = {s, " R3"};
        else if (!l)      s = {s, " R4"};
        else              s = {s, " R5"};
        return {s, " R10 R11"};
    endfunction

    task automatic check_one(input bit asn, input bit u, input bit l,
                             input logic [22:0] wa);
        int byte_a, blk;
        bit in_win, s_rom, s_ram, s_io;
        logic [6:0] exp_v, got_v;
        @(posedge clk);
        #1;
        as_n = asn; uds_n = u; lds_n = l; addr_w = wa;
        byte_a = int'(wa) * 2;
        blk    = byte_a / 16384;
        in_win = byte_a < 32'h20000;
        s_rom  = !asn && in_win && blk == 0;
        s_ram  = !asn && in_win && blk == 1;
        s_io   = !asn && in_win && blk == 7;
        exp_v = {!(s_rom && !u), !(s_rom && !l), !(s_ram && !u), !(s_ram && !l),
                 !(s_io && !u), !(s_io && !l), (s_rom || s_ram || s_io)};
        @(negedge clk);
        got_v = {rom_hi_cs_n, rom_lo_cs_n, ram_hi_cs_n, ram_lo_cs_n,
                 io_hi_cs_n, io_lo_cs_n, decoded};
        total++;
        if (got_v !== exp_v) begin
            bad++;
            $display("FAIL %s byte=%06h as_n=%0b uds_n=%0b lds_n=%0b got=%07b exp=%07b",
                     req_tags(asn, u, l, byte_a), byte_a, asn, u, l, got_v, exp_v);
        end
    endtask

    initial begin
        // R1: idle state with the strobe negated
        @(negedge clk);
        total++;
        if ({rom_hi_cs_n, rom_lo_cs_n, ram_hi_cs_n, ram_lo_cs_n,
             io_hi_cs_n, io_lo_cs_n, decoded} !== 7'b1111110) begin
            bad++;
            $display("FAIL R1 idle got=%07b exp=1111110",
                     {rom_hi_cs_n, rom_lo_cs_n, ram_hi_cs_n, ram_lo_cs_n,
                      io_hi_cs_n, io_lo_cs_n, decoded});
        end
        // Sweep R1..R11: strobes x blocks x offsets x high-bit patterns
        for (int up = 0; up < 3; up++) begin
            for (int blk = 0; blk < 8; blk++) begin
                for (int off = 0; off < 3; off++) begin
                    for (int st = 0; st < 8; st++) begin
                        logic [22:0] wa;
                        int upv, offv;
                        upv  = (up == 0) ? 0 : ((up == 1) ? 1 : 64);
                        offv = (off == 0) ? 0 : ((off == 1) ? 2 : 8191);
                        wa   = 23'((upv << 16) | (blk << 13) | offv);
                        check_one(st[2], st[1], st[0], wa);
                    end
                end
            end
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule